// File: doc/BRIEF.md
# Seven-Slot Four-Lane Pixel Serializer

This block turns a wide parallel pixel word into a few fast serial lanes for a display link. On every falling edge of the pixel clock it captures a 28-bit word. Over the next pixel period it sends that word as four serial lanes, each carrying seven bits in seven equal bit slots. A fifth lane forwards a clock at the pixel rate, so the far end can recover the slot boundaries. The word normally holds three 8-bit colour channels plus the line sync, frame sync and data-valid flags. Which bit goes to which lane is a fixed mapping held in one function.

Timing comes from two clocks. The pixel clock strobes the capture. A bit clock at seven times the pixel rate, phase aligned to it, times the slots. An active-low power-down input resets the block and parks every output. Once power-down is released, a lock counter must count a parameterised number of pixel clocks before the output enables turn on. Until then the outputs model the high-impedance state.

Top module: `pix_serializer7`

## Requirements
- R1: While `pd_n` is low, every output enable and every serial output is 0. This takes effect at once, without waiting for a clock edge.
- R2: The word sent during a pixel period is the value on `din` at the preceding falling edge of `pix_clk`. Changes to `din` while `pix_clk` is low after that edge have no effect on it.
- R3: In slot s (0 to 6), lane l carries `din` bit 7*l+s. Lane 0 carries bits 0..6 and lane 3 carries bits 21..27.
- R4: Slot 0 starts at the first rising edge of `bit_clk` after a falling edge of `pix_clk`. Each later rising edge of `bit_clk` advances one slot, so a captured word leaves one pixel period after capture.
- R5: While enabled, `tx_fclk` follows the slot pattern 1,1,0,0,0,1,1 for slots 0 to 6. It is high for four slots and low for three.
- R6: After `pd_n` rises, the enables stay 0 until `LOCK_CYCLES` falling edges of `pix_clk` have been counted. They rise at the slot 0 that follows the falling edge which completes the count.
- R7: Asserting `pd_n` again restarts the lock count from zero. The next enable needs a full `LOCK_CYCLES` falling edges after release.
- R8: While the enables are 0, `tx_lane` and `tx_fclk` are held at 0.
- R9: The five bits of `tx_oe` (bits 0..3 for the data lanes, bit 4 for the clock lane) always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; its falling edge captures `din` |
| bit_clk | input | 1 | Slot clock, seven times `pix_clk`, phase aligned |
| pd_n | input | 1 | Active-low power-down and asynchronous reset |
| din | input | 28 | Parallel pixel word |
| tx_lane | output | 4 | Serial data bit of each lane |
| tx_fclk | output | 1 | Forwarded pixel-rate clock lane |
| tx_oe | output | 5 | Per-output enable; 0 models high impedance |

## Verification
The assertions assume that `pix_clk` is derived from `bit_clk`: high for four bit periods and low for three, with its edges placed away from the rising edges of `bit_clk`. Under that assumption a capture strobe arrives exactly every seven slots once the link is enabled. The bench builds `pix_clk` by counting `bit_clk` falling edges, so this relation holds by construction. It releases `pd_n` only at the start of the high phase of `pix_clk`. It deliberately disturbs `din` during the low phase, after the capture edge, to test R2.

// File: rtl/ser7_pkg.sv
`timescale 1ns/1ps
package ser7_pkg;

  // slot sequencing: a capture strobe restarts the frame, otherwise wrap at the end
  function automatic int unsigned next_slot(input int unsigned cur, input logic strobe,
                                            input int unsigned slots);
    if (strobe) return 0;
    if (cur >= slots - 1) return 0;
    return cur + 1;
  endfunction

  // forwarded clock level: high in the first 'head' and last 'tail' slots
  function automatic logic fclk_level(input int unsigned slot, input int unsigned slots,
                                      input int unsigned head, input int unsigned tail);
    return (slot < head) || (slot >= slots - tail);
  endfunction

  // word bit that lane 'lane' sends in slot 'slot'
  function automatic int unsigned src_bit(input int unsigned lane, input int unsigned slot,
                                          input int unsigned slots);
    return lane * slots + slot;
  endfunction

endpackage

// File: rtl/ser7_capture.sv
`timescale 1ns/1ps
module ser7_capture #(
  parameter int WORD_W = 28
) (
  input  logic              pix_clk,
  input  logic              pd_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] cap_q
);
  // falling-edge strobe of the parallel word
  always_ff @(negedge pix_clk or negedge pd_n) begin
    if (!pd_n) cap_q <= '0;
    else       cap_q <= din;
  end
endmodule

// File: rtl/ser7_lock_timer.sv
`timescale 1ns/1ps
module ser7_lock_timer #(
  parameter int LOCK_CYCLES = 650000,
  localparam int CW = $clog2(LOCK_CYCLES + 1) < 1 ? 1 : $clog2(LOCK_CYCLES + 1)
) (
  input  logic pix_clk,
  input  logic pd_n,
  output logic locked
);
  logic [CW-1:0] cnt_q;

  assign locked = (cnt_q == CW'(LOCK_CYCLES));

  always_ff @(negedge pix_clk or negedge pd_n) begin
    if (!pd_n)        cnt_q <= '0;
    else if (!locked) cnt_q <= cnt_q + 1'b1;
  end

  // R6: the counter saturates at the lock count and never runs past it
  a_r6_cnt_bound: assert property (@(negedge pix_clk) disable iff (!pd_n)
    cnt_q <= CW'(LOCK_CYCLES));

  // R7: once locked, the timer stays locked until power-down
  a_r7_lock_sticky: assert property (@(negedge pix_clk) disable iff (!pd_n)
    locked |=> locked);
endmodule

// File: rtl/ser7_slotgen.sv
`timescale 1ns/1ps
module ser7_slotgen
  import ser7_pkg::*;
#(
  parameter int WORD_W = 28,
  parameter int SLOTS  = 7,
  parameter int HEAD   = 2,
  parameter int TAIL   = 2,
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic              bit_clk,
  input  logic              pd_n,
  input  logic              pix_clk,
  input  logic              locked,
  input  logic [WORD_W-1:0] cap_q,
  output logic              strobe,
  output logic              en_nxt,
  output logic [SW-1:0]     slot_nxt,
  output logic [WORD_W-1:0] word_nxt,
  output logic              fclk_q,
  output logic              fclk_oe_q
);
  logic              pclk_q;
  logic [SW-1:0]     slot_q;
  logic [WORD_W-1:0] word_q;
  logic              en_q;

  // a frame begins at the first bit edge that sees pix_clk low after high
  assign strobe   = pclk_q & ~pix_clk;
  assign slot_nxt = SW'(next_slot(int'(slot_q), strobe, SLOTS));
  assign word_nxt = strobe ? cap_q : word_q;
  // enables only change at a frame boundary
  assign en_nxt   = strobe ? locked : en_q;

  always_ff @(posedge bit_clk or negedge pd_n) begin
    if (!pd_n) begin
      pclk_q    <= 1'b0;
      slot_q    <= '0;
      word_q    <= '0;
      en_q      <= 1'b0;
      fclk_q    <= 1'b0;
      fclk_oe_q <= 1'b0;
    end else begin
      pclk_q    <= pix_clk;
      slot_q    <= slot_nxt;
      word_q    <= word_nxt;
      en_q      <= en_nxt;
      fclk_q    <= en_nxt & fclk_level(int'(slot_nxt), SLOTS, HEAD, TAIL);
      fclk_oe_q <= en_nxt;
    end
  end

  // R4: with the link enabled, strobes arrive exactly once per SLOTS bit edges
  a_r4_strobe_period: assert property (@(posedge bit_clk) disable iff (!pd_n)
    (strobe && en_q) |-> (slot_q == SW'(SLOTS - 1)));

  // R5: the forwarded clock rises entering the tail slots
  a_r5_fclk_rise: assert property (@(posedge bit_clk) disable iff (!pd_n)
    ($rose(fclk_q) && $past(en_q)) |-> (slot_q == SW'(SLOTS - TAIL)));

  // R5: the forwarded clock falls after the head slots
  a_r5_fclk_fall: assert property (@(posedge bit_clk) disable iff (!pd_n)
    ($fell(fclk_q) && en_q) |-> (slot_q == SW'(HEAD)));

  // R6: the enable may only rise once the lock timer has expired
  a_r6_en_after_lock: assert property (@(posedge bit_clk) disable iff (!pd_n)
    $rose(en_q) |-> locked);

  // R8: the clock lane is quiet while disabled
  a_r8_fclk_quiet: assert property (@(posedge bit_clk) disable iff (!pd_n)
    !fclk_oe_q |-> !fclk_q);
endmodule

// File: rtl/ser7_lane.sv
`timescale 1ns/1ps
module ser7_lane
  import ser7_pkg::*;
#(
  parameter int LANE   = 0,
  parameter int WORD_W = 28,
  parameter int SLOTS  = 7,
  localparam int SW    = $clog2(SLOTS),
  localparam int IW    = $clog2(WORD_W)
) (
  input  logic              bit_clk,
  input  logic              pd_n,
  input  logic              en_nxt,
  input  logic [SW-1:0]     slot_nxt,
  input  logic [WORD_W-1:0] word_nxt,
  output logic              lane_q,
  output logic              lane_oe_q
);
  logic [IW-1:0] idx;

  assign idx = IW'(src_bit(LANE, int'(slot_nxt), SLOTS));

  always_ff @(posedge bit_clk or negedge pd_n) begin
    if (!pd_n) begin
      lane_q    <= 1'b0;
      lane_oe_q <= 1'b0;
    end else begin
      lane_q    <= en_nxt & word_nxt[idx];
      lane_oe_q <= en_nxt;
    end
  end

  // R8: a disabled lane drives 0
  a_r8_lane_quiet: assert property (@(posedge bit_clk) disable iff (!pd_n)
    !lane_oe_q |-> !lane_q);
endmodule

// File: rtl/pix_serializer7.sv
`timescale 1ns/1ps
module pix_serializer7 #(
  parameter int LANES       = 4,
  parameter int SLOTS       = 7,
  parameter int LOCK_CYCLES = 650000,
  localparam int WORD_W     = LANES * SLOTS,
  localparam int SW         = $clog2(SLOTS)
) (
  input  logic              pix_clk,
  input  logic              bit_clk,
  input  logic              pd_n,
  input  logic [WORD_W-1:0] din,
  output logic [LANES-1:0]  tx_lane,
  output logic              tx_fclk,
  output logic [LANES:0]    tx_oe
);
  logic [WORD_W-1:0] cap_q;
  logic              locked;
  logic              strobe;
  logic              en_nxt;
  logic [SW-1:0]     slot_nxt;
  logic [WORD_W-1:0] word_nxt;
  logic              fclk_oe;

  ser7_capture #(.WORD_W(WORD_W)) u_cap (
    .pix_clk(pix_clk), .pd_n(pd_n), .din(din), .cap_q(cap_q)
  );

  ser7_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .pix_clk(pix_clk), .pd_n(pd_n), .locked(locked)
  );

  ser7_slotgen #(.WORD_W(WORD_W), .SLOTS(SLOTS), .HEAD(2), .TAIL(2)) u_slot (
    .bit_clk(bit_clk), .pd_n(pd_n), .pix_clk(pix_clk), .locked(locked),
    .cap_q(cap_q), .strobe(strobe), .en_nxt(en_nxt), .slot_nxt(slot_nxt),
    .word_nxt(word_nxt), .fclk_q(tx_fclk), .fclk_oe_q(fclk_oe)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ser7_lane #(.LANE(l), .WORD_W(WORD_W), .SLOTS(SLOTS)) u_lane (
      .bit_clk(bit_clk), .pd_n(pd_n), .en_nxt(en_nxt), .slot_nxt(slot_nxt),
      .word_nxt(word_nxt), .lane_q(tx_lane[l]), .lane_oe_q(tx_oe[l])
    );
  end

  assign tx_oe[LANES] = fclk_oe;

  // R1: power-down parks every output
  a_r1_pd_parks: assert property (@(posedge bit_clk)
    !pd_n |-> (tx_oe == '0 && tx_lane == '0 && !tx_fclk));

  // R9: the separately registered enables never disagree
  a_r9_oe_agree: assert property (@(posedge bit_clk) disable iff (!pd_n)
    ($countones(tx_oe) == 0) || ($countones(tx_oe) == LANES + 1));
endmodule

// File: tb/pix_serializer7_tb_top.sv
`timescale 1ns/1ps
module pix_serializer7_tb_top;
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;
  localparam int LOCK  = 5;

  logic           bit_clk = 1'b0;
  logic           pix_clk = 1'b1;
  logic           pd_n    = 1'b0;
  logic [W-1:0]   din     = '0;
  logic [LANES-1:0] tx_lane;
  logic           tx_fclk;
  logic [LANES:0] tx_oe;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int           ph     = 0;
  int           per    = 0;
  int           slot_e = 0;
  bit           oe_e   = 0;
  logic [W-1:0] word_e = '0;
  int           falls  = 0;
  int           epoch  = 0;
  bit           done   = 0;

  always #2.5 bit_clk = ~bit_clk;

  pix_serializer7 #(.LANES(LANES), .SLOTS(SLOTS), .LOCK_CYCLES(LOCK)) dut_i (
    .pix_clk(pix_clk), .bit_clk(bit_clk), .pd_n(pd_n), .din(din),
    .tx_lane(tx_lane), .tx_fclk(tx_fclk), .tx_oe(tx_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int p);
    case (p % 4)
      0: return W'($urandom);
      1: return W'(1) << (p % W);
      2: return '1;
      default: return {(W/2){2'b01}};
    endcase
  endfunction

  // one bit-clock period: compare, then advance stimulus and model
  task automatic step(input bit pd_next);
    @(negedge bit_clk);
    for (int l = 0; l < LANES; l++)
      check(!pd_n ? "R1 lane" : (oe_e ? "R2 R3 R4 lane" : "R8 lane"),
            int'(tx_lane[l]), int'(oe_e & word_e[l*SLOTS + slot_e]));
    check(!pd_n ? "R1 fclk" : (oe_e ? "R5 fclk" : "R8 fclk"),
          int'(tx_fclk), int'(oe_e & ((slot_e < 2) || (slot_e >= SLOTS - 2))));
    check(!pd_n ? "R1 oe" : (epoch == 0 ? "R6 R9 oe" : "R7 R9 oe"),
          int'(tx_oe), oe_e ? ((1 << (LANES + 1)) - 1) : 0);
    ph = (ph + 1) % SLOTS;
    pix_clk = (ph < 4);
    if (ph == 0) begin
      per++;
      din = pattern(per);
    end
    if (ph == 5 && (per % 2) == 1) din = ~din;  // R2: disturb after capture
    pd_n = pd_next;
    if (!pd_n) begin
      falls = 0;
      oe_e  = 0;
    end else if (ph == 4) begin
      falls++;
      word_e = din;
      slot_e = 0;
      oe_e   = (falls >= LOCK);
    end else begin
      slot_e = (slot_e + 1) % SLOTS;
    end
  endtask

  task automatic release_pd();
    while (ph != SLOTS - 1) step(1'b0);
    step(1'b1);
  endtask

  initial begin
    #1;
    check("R1 reset oe", int'(tx_oe), 0);
    check("R1 reset lane", int'(tx_lane), 0);
    repeat (12) step(1'b0);
    release_pd();
    repeat (SLOTS * 40) step(1'b1);
    while (ph != 2) step(1'b1);
    repeat (10) step(1'b0);
    epoch = 1;
    release_pd();
    repeat (SLOTS * 30) step(1'b1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bit_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule